// File: doc/BRIEF.md
# Linear CCD Line Timing Sequencer

This block generates the digital drive pattern for a two-phase linear CCD with a resistive-gate photosite and an electronic shutter. Every edge is counted in master-clock cycles. A `start` pulse begins one line, which runs in four steps. First, a transfer pulse moves the integrated charge into the horizontal register. Next comes the normal readout of 2128 pixel periods: 70 leading dummy pixels, 2048 signal pixels and 10 trailing dummy pixels. Then a programmable number of dummy pixels keeps the register clocking. Finally the sequencer returns to idle.

The shutter-reset gate is held high while the line is being read, so charge is drained. It drops once the normal readout is complete, and that opens the integration window. The window stays open until the transfer pulse of the next line closes it. The integration time is therefore set by the dummy count plus the spacing between starts. A second mode also drives a select output that tells the analog stage to pull the resistive gate to its low level for a programmable number of cycles from the moment the shutter opens.

A downstream converter receives a one-cycle sample strobe in each normal pixel, at a programmable delay after the reset-gate pulse. It also receives a flag that marks the 2048 signal pixels. The configuration inputs are captured only when a start is accepted. The following settings are assumed: pixel period P of at least 4, reset width W of at least 1, W + D below P, and overlap between 1 and the transfer width X.

Top module: `lccd_seq`

## Requirements
- R1: After reset `busy`, `xfer_gate`, `rst_gate`, `smp_stb`, `pix_valid`, `rgate_lo_sel` and `hclk1` are 0, while `hclk2`, `sum_gate` and `shut_rst` are 1.
- R2: A `start` seen while idle raises `busy` in the next cycle. `xfer_gate` is high for exactly X = `cfg_xfer_width` cycles, beginning in that same cycle.
- R3: During the transfer pulse, `hclk1` is low except in its last `cfg_overlap` cycles. It stays high into the first pixel of the readout.
- R4: `hclk2` is always the inverse of `hclk1`, and `sum_gate` always equals `hclk2`. In idle, `hclk1` is 0.
- R5: The normal readout is 2128 pixels of P = `cfg_pix_cycles` cycles each. `hclk1` is high in the first floor(P/2) cycles of every pixel.
- R6: `rst_gate` is high in the first W = `cfg_rst_width` cycles of every pixel, both normal and dummy, and low otherwise.
- R7: `smp_stb` pulses for one cycle in each normal pixel, at cycle offset W + `cfg_smp_delay` within the pixel. It never pulses in dummy pixels or in idle.
- R8: `pix_valid` is high for the whole of normal pixels 70 to 2117 (counted from 0), which is 2048 pixels, and low everywhere else.
- R9: `shut_rst` goes high in the first readout cycle after the transfer pulse and holds through the normal readout. It goes low in the cycle after the last normal pixel and stays low until the next transfer pulse ends.
- R10: After the normal readout, N = `cfg_dummy_pix` dummy pixels are clocked, and then `busy` falls. `busy` lasts exactly X + (2128 + N)·P cycles.
- R11: With `cfg_lo_mode` = 1, `rgate_lo_sel` is high for `cfg_lo_window` cycles, starting in the cycle in which `shut_rst` falls. The window may run past the end of `busy`. With `cfg_lo_mode` = 0, `rgate_lo_sel` stays 0.
- R12: A `start` arriving while `busy` is ignored, and changes to the configuration inputs during a line do not alter that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a line (accepted only when idle) |
| cfg_pix_cycles | input | CW | Pixel period P in cycles |
| cfg_rst_width | input | CW | Reset-gate pulse width W |
| cfg_smp_delay | input | CW | Sample strobe delay after the reset pulse |
| cfg_xfer_width | input | CW | Transfer pulse width X |
| cfg_overlap | input | CW | Cycles of `hclk1` high inside the transfer pulse |
| cfg_lo_window | input | CW | Resistive-gate low window length |
| cfg_dummy_pix | input | CW | Dummy pixel count N after readout |
| cfg_lo_mode | input | 1 | 1 enables the resistive-gate low window |
| shut_rst | output | 1 | Shutter reset gate (1 = shutter closed) |
| xfer_gate | output | 1 | Transfer gate |
| hclk1 | output | 1 | Horizontal clock phase 1 |
| hclk2 | output | 1 | Horizontal clock phase 2 |
| sum_gate | output | 1 | Summing gate |
| rst_gate | output | 1 | Output node reset gate |
| rgate_lo_sel | output | 1 | Select low level on both resistive-gate ends |
| smp_stb | output | 1 | Converter sample strobe |
| pix_valid | output | 1 | Signal pixel flag |
| busy | output | 1 | Line in progress |

## Verification
The bound properties check, on every cycle, the relations between outputs that hold whatever the configuration. The transfer pulse only occurs inside `busy` and never coincides with a reset-gate pulse. The shutter is closed whenever a signal pixel is flagged or the transfer pulse ends. The resistive-gate low window only occurs with the shutter open, and the strobe is a single cycle. The exact pixel count and positions, the overlap length, the sample offsets, the signal-pixel window, the dummy padding length, and the fact that configuration and start are ignored mid-line depend on counted cycles. These can only be shown by the bench's scenarios, which compare every cycle against a timeline built from the configuration.

// File: rtl/lccd_seq.sv
module lccd_seq #(
  parameter int CW     = 16,
  parameter int NEFF   = 2048,
  parameter int NLEAD  = 70,
  parameter int NTRAIL = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cfg_pix_cycles,
  input  logic [CW-1:0] cfg_rst_width,
  input  logic [CW-1:0] cfg_smp_delay,
  input  logic [CW-1:0] cfg_xfer_width,
  input  logic [CW-1:0] cfg_overlap,
  input  logic [CW-1:0] cfg_lo_window,
  input  logic [CW-1:0] cfg_dummy_pix,
  input  logic          cfg_lo_mode,
  output logic          shut_rst,
  output logic          xfer_gate,
  output logic          hclk1,
  output logic          hclk2,
  output logic          sum_gate,
  output logic          rst_gate,
  output logic          rgate_lo_sel,
  output logic          smp_stb,
  output logic          pix_valid,
  output logic          busy
);
  localparam int NTOT = NLEAD + NEFF + NTRAIL;
  localparam logic [CW-1:0] LAST_PIX = CW'(NTOT - 1);
  localparam logic [CW-1:0] EFF_LO   = CW'(NLEAD);
  localparam logic [CW-1:0] EFF_HI   = CW'(NLEAD + NEFF);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_READ, S_DUMMY} st_t;

  st_t           st;
  logic [CW-1:0] cnt, pix, win;
  logic [CW-1:0] per_q, rw_q, dly_q, xw_q, ovl_q, wl_q, dn_q;
  logic          wm_q, shut_q;

  logic          pix_end, shifting;
  logic [CW:0]   ovl_sum, smp_at;

  assign pix_end  = (cnt == per_q - 1'b1);
  assign shifting = (st == S_READ) || (st == S_DUMMY);
  assign ovl_sum  = {1'b0, cnt} + {1'b0, ovl_q};
  assign smp_at   = {1'b0, rw_q} + {1'b0, dly_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      pix    <= '0;
      win    <= '0;
      shut_q <= 1'b1;
      per_q  <= '0;
      rw_q   <= '0;
      dly_q  <= '0;
      xw_q   <= '0;
      ovl_q  <= '0;
      wl_q   <= '0;
      dn_q   <= '0;
      wm_q   <= 1'b0;
    end else begin
      if (win != '0) win <= win - 1'b1;
      unique case (st)
        S_IDLE: if (start) begin
          per_q <= cfg_pix_cycles;
          rw_q  <= cfg_rst_width;
          dly_q <= cfg_smp_delay;
          xw_q  <= cfg_xfer_width;
          ovl_q <= cfg_overlap;
          wl_q  <= cfg_lo_window;
          dn_q  <= cfg_dummy_pix;
          wm_q  <= cfg_lo_mode;
          cnt   <= '0;
          st    <= S_XFER;
        end
        S_XFER: if (cnt == xw_q - 1'b1) begin
          cnt    <= '0;
          pix    <= '0;
          shut_q <= 1'b1;
          win    <= '0;
          st     <= S_READ;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_READ: if (pix_end) begin
          cnt <= '0;
          if (pix == LAST_PIX) begin
            pix    <= '0;
            shut_q <= 1'b0;
            if (wm_q) win <= wl_q;
            st <= (dn_q == '0) ? S_IDLE : S_DUMMY;
          end else begin
            pix <= pix + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_DUMMY: if (pix_end) begin
          cnt <= '0;
          if (pix == dn_q - 1'b1) begin
            pix <= '0;
            st  <= S_IDLE;
          end else begin
            pix <= pix + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign xfer_gate    = (st == S_XFER);
  assign hclk1        = (st == S_XFER) ? (ovl_sum >= {1'b0, xw_q})
                                       : (shifting && (cnt < (per_q >> 1)));
  assign hclk2        = !hclk1;
  assign sum_gate     = hclk2;
  assign rst_gate     = shifting && (cnt < rw_q);
  assign smp_stb      = (st == S_READ) && ({1'b0, cnt} == smp_at);
  assign pix_valid    = (st == S_READ) && (pix >= EFF_LO) && (pix < EFF_HI);
  assign busy         = (st != S_IDLE);
  assign shut_rst     = shut_q;
  assign rgate_lo_sel = (win != '0);
endmodule

// File: rtl/lccd_seq_props.sv
module lccd_seq_props (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic shut_rst,
  input logic xfer_gate,
  input logic hclk1,
  input logic hclk2,
  input logic rst_gate,
  input logic rgate_lo_sel,
  input logic smp_stb,
  input logic pix_valid,
  input logic busy
);
  a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && xfer_gate));
  a_r2_xfer_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_gate |-> busy);
  a_r4_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!hclk1 && hclk2));
  a_r6_reset_not_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    rst_gate |-> !xfer_gate);
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !smp_stb);
  a_r8_valid_closed: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (shut_rst && !xfer_gate && busy));
  a_r9_closed_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_gate) |-> shut_rst);
  a_r10_open_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !shut_rst);
  a_r11_window_open: assert property (@(posedge clk) disable iff (!rst_n)
    rgate_lo_sel |-> !shut_rst);
endmodule

bind lccd_seq lccd_seq_props u_props (
  .clk(clk), .rst_n(rst_n), .start(start), .shut_rst(shut_rst),
  .xfer_gate(xfer_gate), .hclk1(hclk1), .hclk2(hclk2), .rst_gate(rst_gate),
  .rgate_lo_sel(rgate_lo_sel), .smp_stb(smp_stb), .pix_valid(pix_valid),
  .busy(busy)
);

// File: tb/tb_lccd_seq.sv
`timescale 1ns/1ps
module tb_lccd_seq;
  localparam int CW = 16;
  localparam int NTOT = 2128;
  localparam int VLO = 70;
  localparam int VHI = 2118;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] cfg_pix_cycles = '0, cfg_rst_width = '0, cfg_smp_delay = '0;
  logic [CW-1:0] cfg_xfer_width = '0, cfg_overlap = '0, cfg_lo_window = '0, cfg_dummy_pix = '0;
  logic cfg_lo_mode = 1'b0;
  logic shut_rst, xfer_gate, hclk1, hclk2, sum_gate, rst_gate, rgate_lo_sel, smp_stb, pix_valid, busy;

  always #10 clk = ~clk;

  lccd_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_pix_cycles(cfg_pix_cycles), .cfg_rst_width(cfg_rst_width),
    .cfg_smp_delay(cfg_smp_delay), .cfg_xfer_width(cfg_xfer_width),
    .cfg_overlap(cfg_overlap), .cfg_lo_window(cfg_lo_window),
    .cfg_dummy_pix(cfg_dummy_pix), .cfg_lo_mode(cfg_lo_mode),
    .shut_rst(shut_rst), .xfer_gate(xfer_gate), .hclk1(hclk1), .hclk2(hclk2),
    .sum_gate(sum_gate), .rst_gate(rst_gate), .rgate_lo_sel(rgate_lo_sel),
    .smp_stb(smp_stb), .pix_valid(pix_valid), .busy(busy)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct { int t; bit v; } ev_t;
  ev_t q[$];

  int d_per, d_rw, d_dly, d_xw, d_ovl, d_wl, d_dn;
  bit d_wm;
  int l_per, l_rw, l_dly, l_xw, l_ovl, l_wl, l_dn;
  bit l_wm, started = 0, aprev = 1, busy_d = 0;
  int rel = 0;
  int m_xfer, m_h1, m_h2, m_rg, m_valid, m_shut, m_win, m_busy, m_smp;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !busy_d) begin
        rel = 0;
        aprev = started ? 1'b0 : 1'b1;
        started = 1;
        l_per = d_per; l_rw = d_rw; l_dly = d_dly; l_xw = d_xw;
        l_ovl = d_ovl; l_wl = d_wl; l_dn = d_dn; l_wm = d_wm;
      end else begin
        rel++;
      end
      busy_d = busy;
      begin
        bit e_busy, e_xfer, e_h1, e_rg, e_valid, e_shut, e_win;
        int k, i, rd_end;
        if (!started) begin
          e_busy = 0; e_xfer = 0; e_h1 = 0; e_rg = 0; e_valid = 0; e_shut = 1; e_win = 0;
        end else begin
          rd_end = l_xw + NTOT * l_per;
          e_busy = rel < rd_end + l_dn * l_per;
          k = (rel >= l_xw) ? (rel - l_xw) % l_per : 0;
          i = (rel >= l_xw) ? (rel - l_xw) / l_per : 0;
          e_xfer = e_busy && rel < l_xw;
          e_h1 = !e_busy ? 1'b0 : (rel < l_xw) ? (rel + l_ovl >= l_xw) : (k < l_per / 2);
          e_rg = e_busy && rel >= l_xw && k < l_rw;
          e_valid = rel >= l_xw && rel < rd_end && i >= VLO && i < VHI;
          e_shut = (rel < l_xw) ? aprev : (rel < rd_end);
          e_win = l_wm && rel >= rd_end && rel < rd_end + l_wl;
        end
        if (busy !== e_busy) m_busy++;
        if (xfer_gate !== e_xfer) m_xfer++;
        if (hclk1 !== e_h1) m_h1++;
        if (hclk2 !== !hclk1 || sum_gate !== hclk2) m_h2++;
        if (rst_gate !== e_rg) m_rg++;
        if (pix_valid !== e_valid) m_valid++;
        if (shut_rst !== e_shut) m_shut++;
        if (rgate_lo_sel !== e_win) m_win++;
      end
      if (smp_stb) begin
        if (q.size() == 0) m_smp++;
        else begin
          ev_t ev;
          ev = q.pop_front();
          if (ev.t != rel || ev.v != pix_valid) m_smp++;
        end
      end
    end
  end

  task automatic clear_counts();
    m_xfer = 0; m_h1 = 0; m_h2 = 0; m_rg = 0; m_valid = 0;
    m_shut = 0; m_win = 0; m_busy = 0; m_smp = 0;
  endtask

  task automatic run_line(input int per, input int rw, input int dly, input int xw,
                          input int ovl, input int dn, input bit wm, input int wl,
                          input bit disturb, input string tag);
    int nval;
    d_per = per; d_rw = rw; d_dly = dly; d_xw = xw; d_ovl = ovl; d_dn = dn; d_wm = wm; d_wl = wl;
    nval = 0;
    for (int i = 0; i < NTOT; i++) begin
      ev_t ev;
      ev.t = xw + i * per + rw + dly;
      ev.v = (i >= VLO && i < VHI);
      if (ev.v) nval++;
      q.push_back(ev);
    end
    clear_counts();
    @(negedge clk);
    cfg_pix_cycles = CW'(per); cfg_rst_width = CW'(rw); cfg_smp_delay = CW'(dly);
    cfg_xfer_width = CW'(xw); cfg_overlap = CW'(ovl); cfg_dummy_pix = CW'(dn);
    cfg_lo_mode = wm; cfg_lo_window = CW'(wl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (40) @(negedge clk);
      cfg_pix_cycles = 16'd9; cfg_rst_width = 16'd4; cfg_smp_delay = 16'd3;
      cfg_xfer_width = 16'd2; cfg_overlap = 16'd1; cfg_dummy_pix = 16'd20;
      cfg_lo_mode = !wm; cfg_lo_window = 16'd2;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (wl + 25) @(negedge clk);
    #1;
    chk(m_xfer == 0, "R2", {tag, " transfer pulse mismatches"}, m_xfer, 0);
    chk(m_h1 == 0, "R3/R5", {tag, " hclk1 mismatches (overlap and pixel phase)"}, m_h1, 0);
    chk(m_h2 == 0, "R4", {tag, " hclk2/sum_gate mismatches"}, m_h2, 0);
    chk(m_rg == 0, "R6", {tag, " rst_gate mismatches"}, m_rg, 0);
    chk(m_smp == 0 && q.size() == 0, "R7", {tag, " strobe mismatches / unseen"}, m_smp + q.size(), 0);
    chk(m_valid == 0, "R8", {tag, " pix_valid mismatches"}, m_valid, 0);
    chk(nval == 2048, "R8", {tag, " signal pixel count"}, nval, 2048);
    chk(m_shut == 0, "R9", {tag, " shut_rst mismatches"}, m_shut, 0);
    chk(m_busy == 0, "R10", {tag, " busy length mismatches"}, m_busy, 0);
    chk(m_win == 0, "R11", {tag, " rgate_lo_sel mismatches"}, m_win, 0);
    if (disturb) chk(busy == 1'b0, "R12", {tag, " busy after ignored start"}, int'(busy), 0);
    q.delete();
  endtask

  bit done = 0;
  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    clear_counts();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(busy == 0 && xfer_gate == 0 && rst_gate == 0 && smp_stb == 0, "R1", "reset busy/xfer/rst/strobe",
        {busy, xfer_gate, rst_gate, smp_stb}, 0);
    chk(pix_valid == 0 && rgate_lo_sel == 0 && hclk1 == 0, "R1", "reset valid/window/hclk1",
        {pix_valid, rgate_lo_sel, hclk1}, 0);
    chk(hclk2 == 1 && sum_gate == 1 && shut_rst == 1, "R1", "reset hclk2/sum/shutter",
        {hclk2, sum_gate, shut_rst}, 7);
    // R11 normal mode: window must stay low even with a nonzero length
    run_line(4, 1, 1, 6, 3, 5, 1'b0, 3, 1'b0, "lineA");
    // R12: config and start disturbed mid-line; window runs past busy (N=0)
    run_line(5, 2, 0, 8, 8, 0, 1'b1, 10, 1'b1, "lineB");
    run_line(6, 3, 2, 4, 1, 3, 1'b1, 7, 1'b0, "lineC");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule